// File: doc/BRIEF.md
# Latency-Aware In-Order Issue Interlock

This block sits at the issue point of a single-issue, in-order pipeline that has integer and floating-point functional units. Each cycle it may be offered one candidate instruction. The candidate carries an operation class, up to two source registers, and an optional destination register. Each register is tagged as belonging to the integer file or to the FP file. For every architectural register the block remembers which class of instruction last wrote it and how many cycles have passed since that writer issued. It lets the candidate issue only when every source has aged far enough for the particular pair of producer class and consumer use. Otherwise it raises a stall, and the upstream stage holds the candidate unchanged.

The spacing comes from a fixed latency table, not from a single load-use bubble. The functional units are taken to be fully pipelined, so only true read-after-write dependences ever cause a stall. A small two-state machine records whether the candidate now at the input is one that is being held. A free-running counter reports how many cycles were lost to stalls.

States: `S_OPEN` means the input holds a fresh candidate or nothing. `S_HELD` means the input holds a candidate that stalled in the previous cycle. Transitions: `S_OPEN -> S_HELD` when a valid candidate stalls. `S_HELD -> S_HELD` while it keeps stalling. `S_HELD -> S_OPEN` when it issues. `S_OPEN -> S_OPEN` on issue or on an empty slot. Reset returns the machine to `S_OPEN`.

Top module: `issue_interlock`

## Requirements
- R1: An FP ALU (class 2) result read by a later FP ALU instruction needs 3 stall cycles. If the consumer is offered in the cycle right after the producer issues, it issues 4 cycles after the producer.
- R2: An FP ALU result read as the stored data of an FP store (class 4, source slot 1) needs 2 stall cycles.
- R3: An FP load (class 3) result needs 1 stall cycle before an FP ALU consumer. It needs 0 stall cycles before the stored data of an FP store.
- R4: An integer load (class 1) result needs 1 stall cycle before any consumer. An integer ALU (class 0) result read by another integer ALU instruction needs 0 stall cycles.
- R5: An integer ALU result read by a branch (class 5) needs 1 stall cycle.
- R6: The address operand of a store (source slot 0) is checked with the integer-consumer latencies. Only source slot 1 of a store uses the stored-data latencies.
- R7: Integer register 0 is never a dependence source. An instruction with `dst_en` low leaves the scoreboard unchanged. Integer and FP registers with the same number are independent.
- R8: `issue_valid` is high exactly when `in_valid` is high and every enabled source is ready. `stall` is high exactly when `in_valid` is high and some source is not ready. The two are never high together, and both are low when `in_valid` is low. Source slot p occupies `src_en[p]`, `src_fp[p]` and `src_reg[p*5 +: 5]`, and `src_fp`/`dst_fp` high selects the FP file.
- R9: `stall_count` increases by exactly one after each cycle in which `stall` is high, wrapping modulo 2^CNT_W, and holds its value otherwise.
- R10: Reset marks every register ready, clears `stall_count` to zero and returns the control state to `S_OPEN`. No writer issued before reset causes a stall afterwards.
- R11: Every cycle that passes after a producer issues counts toward the required spacing, whether or not an instruction is offered in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A candidate instruction is present |
| in_cls | input | 3 | Operation class of the candidate (codes 0 to 5, see R1 to R5) |
| src_en | input | 2 | Per-slot source enable |
| src_fp | input | 2 | Per-slot file select, 1 selects the FP file |
| src_reg | input | 10 | Per-slot source register number, 5 bits per slot |
| dst_en | input | 1 | Candidate writes a destination register |
| dst_fp | input | 1 | Destination file select |
| dst_reg | input | 5 | Destination register number |
| issue_valid | output | 1 | Candidate issues this cycle |
| stall | output | 1 | Candidate is held this cycle |
| stall_count | output | 16 | Running count of stalled cycles |

## Verification
A scoreboard entry that ages too slowly or too fast, or that records the wrong producer class, changes the number of cycles a dependent candidate is held. That difference shows up as a wrong count of `stall` cycles and a wrong `stall_count` increment in the very pair that reads the entry, so each latency-table pair is exercised with its consumer offered in the cycle right after the producer. An entry that is written when it should not be, such as integer register 0, a write with no destination, or the wrong file, shows up as a spurious stall on the next reader. An entry that reset fails to clear shows up in the first cycle after reset.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int MAX_LAT = 3;

    typedef enum logic [2:0] {
        OP_INT_ALU  = 3'd0,
        OP_INT_LOAD = 3'd1,
        OP_FP_ALU   = 3'd2,
        OP_FP_LOAD  = 3'd3,
        OP_FP_STORE = 3'd4,
        OP_BRANCH   = 3'd5
    } op_cls_e;

    typedef enum logic [1:0] {
        USE_INT     = 2'd0,
        USE_BRANCH  = 2'd1,
        USE_FP_ALU  = 2'd2,
        USE_ST_DATA = 2'd3
    } use_e;

    typedef enum logic {
        S_OPEN = 1'b0,
        S_HELD = 1'b1
    } ilk_state_e;

    // How an operand in a given slot of a given class is consumed.
    function automatic use_e use_kind(input logic [2:0] cls, input logic slot);
        use_e u;
        unique case (cls)
            OP_FP_ALU:   u = USE_FP_ALU;
            OP_BRANCH:   u = USE_BRANCH;
            OP_FP_STORE: u = slot ? USE_ST_DATA : USE_INT;
            default:     u = USE_INT;
        endcase
        return u;
    endfunction

    // Stall cycles required between producer class and consumer use.
    function automatic logic [2:0] op_latency(input logic [2:0] prod, input use_e u);
        logic [2:0] l;
        unique case (prod)
            OP_INT_ALU:  l = (u == USE_BRANCH) ? 3'd1 : 3'd0;
            OP_INT_LOAD: l = 3'd1;
            OP_FP_ALU:   l = (u == USE_ST_DATA) ? 3'd2 : 3'd3;
            OP_FP_LOAD:  l = (u == USE_ST_DATA) ? 3'd0 : 3'd1;
            default:     l = 3'd0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
    import ilk_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int AGE_W  = 3,
    parameter int PORTS  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_fp,
    input  logic [REG_AW-1:0]             wr_reg,
    input  logic [2:0]                    wr_cls,
    input  logic [PORTS-1:0]              rd_fp,
    input  logic [PORTS*REG_AW-1:0]       rd_reg,
    output logic [PORTS*AGE_W-1:0]        rd_age,
    output logic [PORTS*3-1:0]            rd_cls
);

    localparam int NREG = 1 << REG_AW;
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
    localparam logic [AGE_W-1:0] AGE_ONE = {{(AGE_W-1){1'b0}}, 1'b1};

    logic [AGE_W-1:0] age_q [2][NREG];
    logic [2:0]       cls_q [2][NREG];

    always_ff @(posedge clk) begin
        for (int f = 0; f < 2; f++) begin
            for (int r = 0; r < NREG; r++) begin
                if (!rst_n) begin
                    age_q[f][r] <= AGE_MAX;
                    cls_q[f][r] <= 3'd0;
                end else if (wr_en && (int'(wr_fp) == f) && (int'(wr_reg) == r)) begin
                    age_q[f][r] <= AGE_ONE;
                    cls_q[f][r] <= wr_cls;
                end else if (age_q[f][r] != AGE_MAX) begin
                    age_q[f][r] <= age_q[f][r] + AGE_ONE;
                end
            end
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        assign rd_age[p*AGE_W +: AGE_W] = age_q[rd_fp[p]][rd_reg[p*REG_AW +: REG_AW]];
        assign rd_cls[p*3 +: 3]         = cls_q[rd_fp[p]][rd_reg[p*REG_AW +: REG_AW]];
    end

endmodule

// File: rtl/ilk_operand_check.sv
module ilk_operand_check
    import ilk_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int AGE_W  = 3,
    parameter bit SLOT   = 1'b0
) (
    input  logic              en,
    input  logic              fp,
    input  logic [REG_AW-1:0] rnum,
    input  logic [2:0]        cons_cls,
    input  logic [AGE_W-1:0]  age,
    input  logic [2:0]        prod_cls,
    output logic              blocked
);

    logic       hardwired_zero;
    logic [2:0] need;

    always_comb begin
        hardwired_zero = !fp && (rnum == '0);
        need           = op_latency(prod_cls, use_kind(cons_cls, SLOT));
        blocked        = en && !hardwired_zero &&
                         ({{(8-AGE_W){1'b0}}, age} < ({5'd0, need} + 8'd1));
    end

endmodule

// File: rtl/ilk_stall_ctr.sv
module ilk_stall_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
    import ilk_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [2:0]            in_cls,
    input  logic [1:0]            src_en,
    input  logic [1:0]            src_fp,
    input  logic [2*REG_AW-1:0]   src_reg,
    input  logic                  dst_en,
    input  logic                  dst_fp,
    input  logic [REG_AW-1:0]     dst_reg,
    output logic                  issue_valid,
    output logic                  stall,
    output logic [CNT_W-1:0]      stall_count
);

    localparam int AGE_W = $clog2(MAX_LAT + 2);
    localparam int PORTS = 2;

    ilk_state_e state, state_nx;
    logic [PORTS*AGE_W-1:0] sb_age;
    logic [PORTS*3-1:0]     sb_cls;
    logic [PORTS-1:0]       blk;
    logic                   any_blk;
    logic                   wr_en;

    ilk_scoreboard #(.REG_AW(REG_AW), .AGE_W(AGE_W), .PORTS(PORTS)) u_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_fp  (dst_fp),
        .wr_reg (dst_reg),
        .wr_cls (in_cls),
        .rd_fp  (src_fp),
        .rd_reg (src_reg),
        .rd_age (sb_age),
        .rd_cls (sb_cls)
    );

    for (genvar p = 0; p < PORTS; p++) begin : g_op
        ilk_operand_check #(.REG_AW(REG_AW), .AGE_W(AGE_W), .SLOT(p == 1)) u_chk (
            .en       (src_en[p]),
            .fp       (src_fp[p]),
            .rnum     (src_reg[p*REG_AW +: REG_AW]),
            .cons_cls (in_cls),
            .age      (sb_age[p*AGE_W +: AGE_W]),
            .prod_cls (sb_cls[p*3 +: 3]),
            .blocked  (blk[p])
        );
    end

    assign any_blk = |blk;

    ilk_stall_ctr #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (stall),
        .count (stall_count)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_OPEN;
        else        state <= state_nx;
    end

    // Next state and outputs
    always_comb begin
        state_nx    = state;
        issue_valid = 1'b0;
        stall       = 1'b0;
        unique case (state)
            S_OPEN: begin
                if (in_valid) begin
                    issue_valid = !any_blk;
                    stall       = any_blk;
                    state_nx    = any_blk ? S_HELD : S_OPEN;
                end
            end
            S_HELD: begin
                issue_valid = in_valid && !any_blk;
                stall       = in_valid && any_blk;
                state_nx    = stall ? S_HELD : S_OPEN;
            end
            default: state_nx = S_OPEN;
        endcase
        wr_en = issue_valid && dst_en && (dst_fp || (dst_reg != '0));
    end

endmodule

// File: rtl/issue_interlock_checker.sv
module issue_interlock_checker
    import ilk_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          in_cls,
    input  logic [1:0]          src_en,
    input  logic [1:0]          src_fp,
    input  logic [2*REG_AW-1:0] src_reg,
    input  logic                dst_en,
    input  logic                dst_fp,
    input  logic [REG_AW-1:0]   dst_reg,
    input  logic                issue_valid,
    input  logic                stall,
    input  logic [CNT_W-1:0]    stall_count,
    input  ilk_state_e          state
);

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_valid && stall));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!issue_valid && !stall));

    assert_held_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HELD) |-> in_valid);

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (stall_count == $past(stall_count) + 1'b1));

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> $stable(stall_count));

    assert_zero_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid
         && (!src_en[0] || (!src_fp[0] && src_reg[REG_AW-1:0] == '0))
         && (!src_en[1] || (!src_fp[1] && src_reg[2*REG_AW-1:REG_AW] == '0)))
        |-> issue_valid);

    assert_fp_chain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && in_cls == OP_FP_ALU && dst_en && dst_fp)
        |=> (!(in_valid && in_cls == OP_FP_ALU && src_en[0] && src_fp[0]
               && src_reg[REG_AW-1:0] == $past(dst_reg)) || stall));

endmodule

bind issue_interlock issue_interlock_checker #(.REG_AW(REG_AW), .CNT_W(CNT_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_cls      (in_cls),
    .src_en      (src_en),
    .src_fp      (src_fp),
    .src_reg     (src_reg),
    .dst_en      (dst_en),
    .dst_fp      (dst_fp),
    .dst_reg     (dst_reg),
    .issue_valid (issue_valid),
    .stall       (stall),
    .stall_count (stall_count),
    .state       (state)
);

// File: tb/issue_interlock_test.sv
module issue_interlock_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_cls = 3'd0;
    logic [1:0]  src_en = 2'b00;
    logic [1:0]  src_fp = 2'b00;
    logic [9:0]  src_reg = '0;
    logic        dst_en = 1'b0;
    logic        dst_fp = 1'b0;
    logic [4:0]  dst_reg = '0;
    logic        issue_valid;
    logic        stall;
    logic [15:0] stall_count;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int total_stalls = 0;

    always #2 clk = ~clk;

    issue_interlock uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .src_en(src_en), .src_fp(src_fp), .src_reg(src_reg),
        .dst_en(dst_en), .dst_fp(dst_fp), .dst_reg(dst_reg),
        .issue_valid(issue_valid), .stall(stall), .stall_count(stall_count)
    );

    // Vector: {req[3:0], pcls[2:0], fp, reg[4:0], ccls[2:0], slot, exp[2:0]}
    localparam int NVEC = 11;
    localparam logic [19:0] VEC [NVEC] = '{
        {4'd1,  3'd2, 1'b1, 5'd4,  3'd2, 1'b0, 3'd3},  // R1 FP ALU -> FP ALU
        {4'd2,  3'd2, 1'b1, 5'd4,  3'd4, 1'b1, 3'd2},  // R2 FP ALU -> store data
        {4'd3,  3'd3, 1'b1, 5'd0,  3'd2, 1'b1, 3'd1},  // R3 FP load -> FP ALU
        {4'd3,  3'd3, 1'b1, 5'd6,  3'd4, 1'b1, 3'd0},  // R3 FP load -> store data
        {4'd4,  3'd1, 1'b0, 5'd1,  3'd0, 1'b0, 3'd1},  // R4 int load -> int ALU
        {4'd4,  3'd1, 1'b0, 5'd2,  3'd5, 1'b0, 3'd1},  // R4 int load -> branch
        {4'd4,  3'd0, 1'b0, 5'd1,  3'd0, 1'b1, 3'd0},  // R4 int ALU -> int ALU
        {4'd5,  3'd0, 1'b0, 5'd3,  3'd5, 1'b0, 3'd1},  // R5 int ALU -> branch
        {4'd6,  3'd0, 1'b0, 5'd1,  3'd4, 1'b0, 3'd0},  // R6 int ALU -> store address
        {4'd6,  3'd1, 1'b0, 5'd3,  3'd4, 1'b0, 3'd1},  // R6 int load -> store address
        {4'd7,  3'd1, 1'b0, 5'd0,  3'd0, 1'b0, 3'd0}   // R7 int r0 never a source
    };

    task automatic check(input string req, input int actual, input int expected, input string what);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; src_en = 2'b00; dst_en = 1'b0;
        end
    endtask

    // Offer a producer writing (fp, r) at the next negedge; it must issue.
    task automatic offer_producer(input string req, input logic [2:0] cls, input logic fp,
                                  input logic [4:0] r, input logic wr);
        @(negedge clk);
        in_valid = 1'b1; in_cls = cls; src_en = 2'b00; src_fp = 2'b00; src_reg = '0;
        dst_en = wr; dst_fp = fp; dst_reg = r;
        #1;
        check(req, int'(issue_valid), 1, "producer issue");
    endtask

    // Offer a consumer reading (fp, r) in a slot; count stall cycles until issue.
    task automatic offer_consumer(input string req, input logic [2:0] cls, input logic slot,
                                  input logic fp, input logic [4:0] r, input int expected);
        int n;
        int c0;
        @(negedge clk);
        in_valid = 1'b1; in_cls = cls; dst_en = 1'b0; dst_fp = 1'b0; dst_reg = '0;
        src_en = 2'b00; src_fp = 2'b00; src_reg = '0;
        src_en[slot] = 1'b1; src_fp[slot] = fp;
        if (slot) src_reg[9:5] = r; else src_reg[4:0] = r;
        #1;
        c0 = int'(stall_count);
        n = 0;
        while (!issue_valid && n < 10) begin
            n++;
            @(negedge clk);
            #1;
        end
        check(req, n, expected, "stall cycles");
        check(req, int'(stall_count) - c0, expected, "counter increment");
        total_stalls += n;
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        #1;
        check("R10", int'(stall_count), 0, "count in reset");
        check("R8", int'(issue_valid) + int'(stall), 0, "outputs idle in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10", int'(stall_count), 0, "count after reset");

        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[v][19:16]);
            offer_producer(tag, VEC[v][15:13], VEC[v][12], VEC[v][11:7], 1'b1);
            offer_consumer(tag, VEC[v][6:4], VEC[v][3], VEC[v][12], VEC[v][11:7], int'(VEC[v][2:0]));
            idle_cycles(6);
        end
        check("R9", int'(stall_count), total_stalls, "accumulated count");

        // R7: same number in the other file is independent
        offer_producer("R7", 3'd2, 1'b1, 5'd9, 1'b1);
        offer_consumer("R7", 3'd0, 1'b0, 1'b0, 5'd9, 0);
        idle_cycles(6);

        // R7: no destination leaves the scoreboard unchanged
        offer_producer("R7", 3'd2, 1'b1, 5'd10, 1'b0);
        offer_consumer("R7", 3'd2, 1'b0, 1'b1, 5'd10, 0);
        idle_cycles(6);

        // R11: idle cycles count toward spacing
        offer_producer("R11", 3'd2, 1'b1, 5'd11, 1'b1);
        idle_cycles(2);
        offer_consumer("R11", 3'd2, 1'b1, 1'b1, 5'd11, 1);
        idle_cycles(1);
        #1;
        check("R8", int'(issue_valid) + int'(stall), 0, "outputs low without candidate");

        // R10: reset clears an in-flight writer and the counter
        offer_producer("R10", 3'd2, 1'b1, 5'd12, 1'b1);
        @(negedge clk);
        in_valid = 1'b0; dst_en = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10", int'(stall_count), 0, "count cleared");
        offer_consumer("R10", 3'd2, 1'b0, 1'b1, 5'd12, 0);
        idle_cycles(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule